// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control unit of a small 16-bit processor core. It watches an external interrupt request line on every clock and, while interrupts are enabled, remembers a request in a hidden pending flag. The core's fetch logic asks for permission to fetch through `fetch_req_i`. With nothing pending the fetch is granted at once. With a request pending the sequencer takes over instead and performs the hardware entry: a two-cycle acknowledge strobe, then the return-address push, then the handler vector load.

The same engine also serves the two interrupt instructions. A software trap request with an 8-bit operand runs the entry without the acknowledge strobe. A return request pops the saved instruction address back into the instruction pointer. The block owns the instruction pointer (IP), stack pointer (SP), interrupt-enable flag and interrupt-ID register. It reaches memory through a word-wide request/acknowledge port. A memory word at address A is big-endian: byte A goes on bits 15:8 and byte A+1 on bits 7:0.

The controller states are as follows.
- IDLE waits.
- ACK1 and ACK2 drive the acknowledge strobe. ACK2 latches the ID.
- PUSH writes the return address.
- VEC reads the handler address.
- POP reads the saved address on return.

The transitions are as follows.
- IDLE goes to ACK1 on a fetch with a request pending.
- IDLE goes to PUSH on an enabled software trap.
- IDLE goes to POP on a return request.
- ACK1 goes to ACK2, and ACK2 goes to PUSH.
- PUSH goes to VEC on acknowledge.
- VEC and POP go back to IDLE on acknowledge.

Top module: `irq_seq_top`

## Requirements
- R1: After reset, the following all read zero: `ie_o`, `ip_o`, `iid_o`, `ira_o`, `mem_req_o` and `busy_o`. `sp_o` equals `SP_RST`, and the pending flag is clear.
- R2: A request on `irq_i` while `ie_o` is 0 is ignored: a later fetch request is granted (`fetch_go_o`=1) and no entry starts.
- R3: A request accepted with `ie_o`=1 is held without any bus activity (`busy_o`=0, `ira_o`=0) until `fetch_req_i` is raised.
- R4: On a fetch request with a request pending, `fetch_go_o` stays 0 and `ira_o` is high for exactly two consecutive cycles. The `gio_data_i` byte present in the second cycle becomes `iid_o`, zero-extended. The byte in the first cycle is not used.
- R5: On entry, SP is decremented by 2 and the `next_ip_i` value captured at entry is written (`mem_we_o`=1) to the new SP address.
- R6: After the push, the sequencer reads the word at `VEC_ADDR` (default 0xFFFC) and loads it into IP. The byte at 0xFFFC is the upper half, so bytes 0x12 and 0x34 give IP 0x1234.
- R7: Interrupt enable is cleared when an entry starts. A request arriving afterwards is not accepted until `ie_set_i` is pulsed again.
- R8: Each memory step holds `mem_req_o`, `mem_addr_o` and the state until `mem_ack_i`. A hardware entry lasts 4+2L busy cycles when every access waits L cycles.
- R9: A software trap (`swi_req_i`) while `ie_o`=0 has no effect: SP, IP and the ID stay unchanged, and no memory request is made.
- R10: A software trap while `ie_o`=1 loads `iid_o` from `swi_id_i` and then runs the push and vector load without raising `ira_o` (2+2L busy cycles).
- R11: A return request (`iret_req_i`) clears `iid_o`, reads the word at SP into IP, then adds 2 to SP.
- R12: Further requests that arrive while one is already pending merge into it and cause a single entry only.
- R13: `fetch_go_o` is 1 exactly when `fetch_req_i` is high, the sequencer is idle and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 1 | External interrupt request |
| fetch_req_i | input | 1 | Core is at an instruction boundary and wants to fetch |
| fetch_go_o | output | 1 | Fetch granted (no interrupt taken) |
| next_ip_i | input | 16 | Address of the next instruction, saved on entry |
| swi_req_i | input | 1 | Software trap instruction request |
| swi_id_i | input | 8 | Operand of the software trap |
| iret_req_i | input | 1 | Interrupt return instruction request |
| ie_set_i | input | 1 | Software sets interrupt enable |
| ie_clr_i | input | 1 | Software clears interrupt enable |
| ira_o | output | 1 | Interrupt acknowledge strobe |
| gio_data_i | input | 8 | I/O bus data carrying the interrupt ID |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, big-endian word |
| mem_ack_i | input | 1 | Memory access complete |
| ip_o | output | 16 | Instruction pointer |
| sp_o | output | 16 | Stack pointer |
| iid_o | output | 16 | Interrupt-ID register |
| ie_o | output | 1 | Interrupt-enable flag |
| busy_o | output | 1 | Sequencer not idle |

## Verification
Hardware entries are run with two different bytes on the I/O bus, one in each strobe cycle. This separates latching in the second cycle from latching in the first. Entries are also run with zero and nonzero memory wait. The busy-cycle count then shows whether each access really stalls for its acknowledge.

Requests are raised with enable off, with enable on but no fetch, and held for several cycles. These cases separate gating, deferral to the fetch boundary and merging. Software traps with enable on and off, and a return that pops the pushed address, show that both instruction paths share the push and vector steps and leave state alone when they should.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ACK1,
        S_ACK2,
        S_PUSH,
        S_VEC,
        S_POP
    } seq_state_t;
endpackage

// File: rtl/irq_pend.sv
module irq_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_i,
    input  logic ie_i,
    input  logic take_i,
    output logic pend_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (take_i)
            pend_q <= 1'b0;
        else if (irq_i && ie_i)
            pend_q <= 1'b1;
    end

    assign pend_o = pend_q;

    // a pending request survives until it is taken (merge, no loss)
    p_merge_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !take_i) |=> pend_q);

    // with enable off nothing new becomes pending
    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !ie_i) |=> !pend_q);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
    import irqseq_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int IDW    = 8,
    parameter logic [AW-1:0] SP_RST = '0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pend_i,
    input  logic           fetch_req_i,
    input  logic [AW-1:0]  next_ip_i,
    input  logic           swi_req_i,
    input  logic [IDW-1:0] swi_id_i,
    input  logic           iret_req_i,
    input  logic           ie_set_i,
    input  logic           ie_clr_i,
    input  logic [IDW-1:0] gio_data_i,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ack_i,
    output seq_state_t     state_o,
    output logic           take_o,
    output logic           fetch_go_o,
    output logic [AW-1:0]  ip_o,
    output logic [AW-1:0]  sp_o,
    output logic [AW-1:0]  ret_ip_o,
    output logic [DW-1:0]  iid_o,
    output logic           ie_o
);
    localparam logic [AW-1:0] WSTEP = AW'(2);

    seq_state_t state_q, state_d;
    logic [AW-1:0] ip_q, sp_q, ret_q;
    logic [DW-1:0] iid_q;
    logic ie_q;
    logic idle, take, swi_go, iret_go;

    assign idle    = (state_q == S_IDLE);
    assign take    = idle && fetch_req_i && pend_i;
    assign swi_go  = idle && !take && swi_req_i && ie_q;
    assign iret_go = idle && !take && !swi_req_i && iret_req_i;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (take)         state_d = S_ACK1;
                else if (swi_go)  state_d = S_PUSH;
                else if (iret_go) state_d = S_POP;
            end
            S_ACK1: state_d = S_ACK2;
            S_ACK2: state_d = S_PUSH;
            S_PUSH: if (mem_ack_i) state_d = S_VEC;
            S_VEC:  if (mem_ack_i) state_d = S_IDLE;
            S_POP:  if (mem_ack_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q  <= '0;
            sp_q  <= SP_RST;
            ret_q <= '0;
            iid_q <= '0;
            ie_q  <= 1'b0;
        end else begin
            if (take || swi_go) begin
                ie_q  <= 1'b0;
                ret_q <= next_ip_i;
            end else if (ie_clr_i) begin
                ie_q <= 1'b0;
            end else if (ie_set_i) begin
                ie_q <= 1'b1;
            end
            if (swi_go) begin
                iid_q <= DW'(swi_id_i);
                sp_q  <= sp_q - WSTEP;
            end
            if (iret_go)
                iid_q <= '0;
            if (state_q == S_ACK2) begin
                iid_q <= DW'(gio_data_i);
                sp_q  <= sp_q - WSTEP;
            end
            if (state_q == S_VEC && mem_ack_i)
                ip_q <= AW'(mem_rdata_i);
            if (state_q == S_POP && mem_ack_i) begin
                ip_q <= AW'(mem_rdata_i);
                sp_q <= sp_q + WSTEP;
            end
        end
    end

    assign state_o    = state_q;
    assign take_o     = take;
    assign fetch_go_o = idle && fetch_req_i && !pend_i;
    assign ip_o       = ip_q;
    assign sp_o       = sp_q;
    assign ret_ip_o   = ret_q;
    assign iid_o      = iid_q;
    assign ie_o       = ie_q;

    // enable is already off when the acknowledge begins
    p_ie_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACK1) |-> !ie_q);

    // a taken request leads straight into the acknowledge
    p_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state_q == S_ACK1));

    // a completed pop raises SP by one word
    p_pop_sp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POP && mem_ack_i) |=> (sp_q == $past(sp_q) + WSTEP));

    // a disabled software trap leaves SP untouched
    p_swi_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && swi_req_i && !ie_q && !fetch_req_i) |=> $stable(sp_q));
endmodule

// File: rtl/irq_bus.sv
module irq_bus
    import irqseq_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter logic [AW-1:0] VEC_ADDR = 16'hFFFC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_state_t    state_i,
    input  logic [AW-1:0] sp_i,
    input  logic [AW-1:0] ret_ip_i,
    input  logic          mem_ack_i,
    output logic          ira_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o
);
    // outputs per state
    always_comb begin
        ira_o       = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_i)
            S_IDLE: ;
            S_ACK1, S_ACK2: ira_o = 1'b1;
            S_PUSH: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_i;
                mem_wdata_o = DW'(ret_ip_i);
            end
            S_VEC: begin
                mem_req_o  = 1'b1;
                mem_addr_o = VEC_ADDR;
            end
            S_POP: begin
                mem_req_o  = 1'b1;
                mem_addr_o = sp_i;
            end
            default: ;
        endcase
    end

    p_ira_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ira_o) |=> ira_o);

    p_ira_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ira_o && $past(ira_o)) |=> !ira_o);

    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

// File: rtl/irq_seq_top.sv
module irq_seq_top
    import irqseq_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int IDW = 8,
    parameter logic [AW-1:0] SP_RST   = 16'h0000,
    parameter logic [AW-1:0] VEC_ADDR = 16'hFFFC
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           irq_i,
    input  logic           fetch_req_i,
    output logic           fetch_go_o,
    input  logic [AW-1:0]  next_ip_i,
    input  logic           swi_req_i,
    input  logic [IDW-1:0] swi_id_i,
    input  logic           iret_req_i,
    input  logic           ie_set_i,
    input  logic           ie_clr_i,
    output logic           ira_o,
    input  logic [IDW-1:0] gio_data_i,
    output logic           mem_req_o,
    output logic           mem_we_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic [DW-1:0]  mem_wdata_o,
    input  logic [DW-1:0]  mem_rdata_i,
    input  logic           mem_ack_i,
    output logic [AW-1:0]  ip_o,
    output logic [AW-1:0]  sp_o,
    output logic [DW-1:0]  iid_o,
    output logic           ie_o,
    output logic           busy_o
);
    seq_state_t state;
    logic pend, take;
    logic [AW-1:0] sp, ret_ip;

    irq_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_i  (irq_i),
        .ie_i   (ie_o),
        .take_i (take),
        .pend_o (pend)
    );

    irq_ctl #(.AW(AW), .DW(DW), .IDW(IDW), .SP_RST(SP_RST)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend),
        .fetch_req_i (fetch_req_i),
        .next_ip_i   (next_ip_i),
        .swi_req_i   (swi_req_i),
        .swi_id_i    (swi_id_i),
        .iret_req_i  (iret_req_i),
        .ie_set_i    (ie_set_i),
        .ie_clr_i    (ie_clr_i),
        .gio_data_i  (gio_data_i),
        .mem_rdata_i (mem_rdata_i),
        .mem_ack_i   (mem_ack_i),
        .state_o     (state),
        .take_o      (take),
        .fetch_go_o  (fetch_go_o),
        .ip_o        (ip_o),
        .sp_o        (sp),
        .ret_ip_o    (ret_ip),
        .iid_o       (iid_o),
        .ie_o        (ie_o)
    );

    irq_bus #(.AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .sp_i        (sp),
        .ret_ip_i    (ret_ip),
        .mem_ack_i   (mem_ack_i),
        .ira_o       (ira_o),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o)
    );

    assign sp_o   = sp;
    assign busy_o = (state != S_IDLE);

    // the strobe never overlaps a memory access
    p_ira_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ira_o |-> !mem_req_o);

    // no fetch grant while an entry is running
    p_fetch_r13: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !fetch_go_o);
endmodule

// File: tb/irq_seq_top_tb.sv
module irq_seq_top_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq = 0, fetch_req = 0, swi_req = 0, iret_req = 0, ie_set = 0, ie_clr = 0;
    logic [15:0] next_ip = 0;
    logic [7:0] swi_id = 0, gio = 0;
    logic mem_ack = 0;
    logic [15:0] mem_rdata = 0;
    logic fetch_go, ira, mem_req, mem_we, ie, busy;
    logic [15:0] mem_addr, mem_wdata, ip, sp, iid;

    int n_tests = 0, n_fail = 0;
    int lat = 0, wcnt = 0, n_writes = 0;
    logic [15:0] stk_addr = 16'h0, stk_data = 16'h0;
    logic [15:0] vec_word = 16'h1234;

    always #2.5 clk = ~clk;

    irq_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .fetch_req_i(fetch_req),
        .fetch_go_o(fetch_go), .next_ip_i(next_ip), .swi_req_i(swi_req),
        .swi_id_i(swi_id), .iret_req_i(iret_req), .ie_set_i(ie_set),
        .ie_clr_i(ie_clr), .ira_o(ira), .gio_data_i(gio), .mem_req_o(mem_req),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack), .ip_o(ip), .sp_o(sp),
        .iid_o(iid), .ie_o(ie), .busy_o(busy)
    );

    // memory responder: acknowledges after lat waiting cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && wcnt >= lat) begin
                mem_ack = 1'b1;
                wcnt = 0;
                if (mem_we) begin
                    stk_addr = mem_addr;
                    stk_data = mem_wdata;
                    n_writes++;
                end
                if (mem_addr == 16'hFFFC)      mem_rdata = vec_word;
                else if (mem_addr == stk_addr) mem_rdata = stk_data;
                else                           mem_rdata = 16'hDEAD;
            end else begin
                mem_ack = 1'b0;
                if (mem_req) wcnt++;
                else wcnt = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_ie_set();
        @(negedge clk); ie_set = 1;
        @(negedge clk); ie_set = 0;
    endtask

    // wait until idle, returning busy cycles seen (sampled at negedge)
    task automatic wait_idle(output int cyc, output bit saw_ira);
        cyc = 0; saw_ira = 0;
        for (int i = 0; i < 200; i++) begin
            if (!busy) break;
            cyc++;
            if (ira) saw_ira = 1;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(ie == 0 && ip == 0 && iid == 0 && !ira && !mem_req && !busy, "R1", {ip[14:0], ie}, 16'h0);
        chk(sp == 16'h0000, "R1 sp", sp, 16'h0000);
    endtask

    task automatic t_disabled_irq();
        @(negedge clk); irq = 1;
        @(negedge clk); irq = 0;
        @(negedge clk); fetch_req = 1; #1;
        chk(fetch_go == 1, "R2", 16'(fetch_go), 16'h1);
        @(negedge clk); fetch_req = 0;
        chk(!busy && !ira, "R2 no entry", 16'(busy), 16'h0);
    endtask

    // hardware entry with two distinct ID bytes and memory latency L
    task automatic t_hw_entry(input int L, input logic [15:0] nip, input logic [7:0] b1,
                              input logic [7:0] b2, input int nirq);
        int cyc; bit sa; logic [15:0] sp0; int w0;
        lat = L; sp0 = sp; w0 = n_writes;
        pulse_ie_set();
        chk(ie == 1, "R7 set", 16'(ie), 16'h1);
        @(negedge clk); irq = 1;
        for (int i = 1; i < nirq; i++) @(negedge clk);
        @(negedge clk); irq = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!busy && !ira && !mem_req, "R3 held", 16'(busy), 16'h0);
        end
        next_ip = nip; fetch_req = 1; #1;
        chk(fetch_go == 0, "R4 no grant", 16'(fetch_go), 16'h0);
        @(negedge clk); fetch_req = 0; gio = b1;
        chk(ira == 1, "R4 ira c1", 16'(ira), 16'h1);
        chk(ie == 0, "R7 cleared", 16'(ie), 16'h0);
        @(negedge clk); gio = b2;
        chk(ira == 1, "R4 ira c2", 16'(ira), 16'h1);
        @(negedge clk); gio = 8'hEE;
        chk(ira == 0, "R4 ira off", 16'(ira), 16'h0);
        wait_idle(cyc, sa);
        chk(cyc + 2 == 4 + 2 * L, "R8 cycles", 16'(cyc + 2), 16'(4 + 2 * L));
        chk(iid == {8'h00, b2}, "R4 id", iid, {8'h00, b2});
        chk(sp == sp0 - 16'd2, "R5 sp", sp, sp0 - 16'd2);
        chk(stk_addr == sp0 - 16'd2 && stk_data == nip, "R5 push", stk_data, nip);
        chk(n_writes == w0 + 1, "R12 single push", 16'(n_writes - w0), 16'h1);
        chk(ip == vec_word, "R6 vector", ip, vec_word);
    endtask

    task automatic t_irq_after_entry();
        @(negedge clk); irq = 1;
        @(negedge clk); irq = 0;
        @(negedge clk); fetch_req = 1; #1;
        chk(fetch_go == 1, "R7 blocked", 16'(fetch_go), 16'h1);
        @(negedge clk); fetch_req = 0;
        chk(!busy, "R7 idle", 16'(busy), 16'h0);
    endtask

    task automatic t_iret(input logic [15:0] exp_ip);
        int cyc; bit sa; logic [15:0] sp0;
        sp0 = sp;
        @(negedge clk); iret_req = 1;
        @(negedge clk); iret_req = 0;
        wait_idle(cyc, sa);
        chk(ip == exp_ip, "R11 ip", ip, exp_ip);
        chk(sp == sp0 + 16'd2, "R11 sp", sp, sp0 + 16'd2);
        chk(iid == 16'h0, "R11 id", iid, 16'h0);
    endtask

    task automatic t_swi_off();
        logic [15:0] sp0, ip0, id0;
        sp0 = sp; ip0 = ip; id0 = iid;
        @(negedge clk); ie_clr = 1;
        @(negedge clk); ie_clr = 0; swi_req = 1; swi_id = 8'h77;
        @(negedge clk); swi_req = 0;
        chk(!busy && !mem_req, "R9 idle", 16'(busy), 16'h0);
        @(negedge clk);
        chk(sp == sp0 && ip == ip0 && iid == id0, "R9 state", sp, sp0);
    endtask

    task automatic t_swi_on(input int L);
        int cyc; bit sa; logic [15:0] sp0;
        lat = L; sp0 = sp;
        pulse_ie_set();
        next_ip = 16'h0300; swi_id = 8'h5A; vec_word = 16'h4321;
        @(negedge clk); swi_req = 1;
        @(negedge clk); swi_req = 0;
        wait_idle(cyc, sa);
        chk(cyc == 2 + 2 * L, "R10 cycles", 16'(cyc), 16'(2 + 2 * L));
        chk(!sa, "R10 no ira", 16'(sa), 16'h0);
        chk(iid == 16'h005A, "R10 id", iid, 16'h005A);
        chk(stk_data == 16'h0300 && sp == sp0 - 16'd2, "R10 push", stk_data, 16'h0300);
        chk(ip == 16'h4321, "R10 vector", ip, 16'h4321);
        chk(ie == 0, "R10 ie", 16'(ie), 16'h0);
    endtask

    task automatic t_merge_after();
        pulse_ie_set();
        @(negedge clk); fetch_req = 1; #1;
        chk(fetch_go == 1, "R12 no second", 16'(fetch_go), 16'h1);
        chk(fetch_go == 1, "R13 grant", 16'(fetch_go), 16'h1);
        @(negedge clk); fetch_req = 0; #1;
        chk(fetch_go == 0, "R13 no req", 16'(fetch_go), 16'h0);
    endtask

    initial begin
        #100000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_disabled_irq();
        t_hw_entry(0, 16'h0004, 8'hA1, 8'h12, 1);
        t_irq_after_entry();
        t_iret(16'h0004);
        t_hw_entry(3, 16'h0456, 8'h33, 8'hC7, 4);
        t_iret(16'h0456);
        t_merge_after();
        t_swi_off();
        t_swi_on(0);
        t_iret(16'h0300);
        t_swi_on(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule